// File: doc/BRIEF.md
# Asynchronous DRAM access sequencer

This block turns single-word read and write requests from a host into the strobe sequence of a classic asynchronous DRAM. The DRAM has one set of address pins shared by the row and column halves of the address. The host offers a request on a valid/ready handshake: a write flag, a full word address, write data, and two ordering bits. The sequencer puts the row half on the pins and drops the row strobe. It then switches the pins to the column half and drops the column strobe. Write data goes out on a split data bus with a drive enable, and read data is returned with a one-cycle valid pulse.

Every minimum delay is given in nanoseconds and turned into clock cycles at elaboration. These delays are the address setup and hold around each strobe, the access times counted from the row and column strobes, and the row cycle time. Two mode bits choose the ordering of the strobes. One chooses whether output-enable falls before or after the column strobe in a read. The other makes the same choice for write-enable in a write. At the end of an access the strobes are released in order: output-enable and write-enable first, then the column strobe, then the row strobe. After that the sequencer waits out the row precharge and only then accepts the next request.

Top module: `adram_seq`

## Requirements
- R1: After reset the row, column, write-enable and output-enable strobes are high, the data drive enable is low, `rd_valid` is low and `req_ready` is high.
- R2: The high `ROW_W` bits of `req_addr` are on `mem_a` in the cycle before the row strobe falls and stay there for at least the row hold time after it. The low `COL_W` bits are on `mem_a` when the column strobe falls.
- R3: With `late_rd`=0, output-enable is already low when the column strobe falls. With `late_rd`=1, output-enable is still high at that point and falls later while the column strobe is low.
- R4: With `late_wr`=0, write-enable is already low when the column strobe falls. With `late_wr`=1, it is still high then and falls later. The data drive enable is high whenever write-enable is low.
- R5: The data drive enable is high only during writes. It is never high while output-enable is low, and it is low in the cycle before output-enable falls.
- R6: Read data is sampled from `mem_dq_in` only after at least tRAC has passed since the row strobe fell and at least tCAC has passed since the column strobe fell. It is returned on `rd_data` together with a `rd_valid` pulse that lasts exactly one cycle.
- R7: An access ends in this order: output-enable and write-enable rise while the column strobe is still low, then the column strobe rises while the row strobe is still low, then the row strobe rises. The column strobe is never low while the row strobe is high.
- R8: `req_ready` falls in the cycle after a request is accepted and stays low until the precharge wait ends. Successive falls of the row strobe are at least tRC apart.
- R9: A read returns the value that the most recent write to the same address stored, for every combination of the ordering bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row half in the upper bits |
| req_wdata | input | DATA_W | Write data |
| late_rd | input | 1 | 1 = output-enable after the column strobe |
| late_wr | input | 1 | 1 = write-enable after the column strobe |
| rd_valid | output | 1 | One-cycle read data valid |
| rd_data | output | DATA_W | Read data |
| mem_a | output | max(ROW_W,COL_W) | Shared row/column address pins |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write-enable, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| mem_dq_out | output | DATA_W | Data to the DRAM |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DATA_W | Data from the DRAM |

## Verification
The bench builds the block with a 20 ns clock and a deliberately slow part. These are 4-bit row and column halves, a 30 ns row hold, tRAC of 180 ns, tCAC of 70 ns and tRC of 400 ns. The resulting delays are a two-cycle row hold and a five-cycle column wait, in which tRAC rather than tCAC is the limit. The precharge wait is seven cycles, so the tRC spacing between row strobes is actually constrained rather than met trivially. The bench's memory model returns garbage until both access times have passed, so reading the data too early shows up as a wrong value.

// File: rtl/adram_pkg.sv
package adram_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ROW_SU,
    S_RAS_HOLD,
    S_COL_SU,
    S_CAS_LEAD,
    S_CAS_WAIT,
    S_OE_OFF,
    S_CAS_OFF,
    S_PRE
  } seq_state_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
    logic sel_col;
    logic ready;
  } pin_ctl_t;

  function automatic int ns_to_cyc(int ns, int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adram_timer.sv
module adram_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/adram_addr_mux.sv
module adram_addr_mux #(
  parameter int ROW_W = 9,
  parameter int COL_W = 9,
  parameter int PIN_W = 9
) (
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic                   sel_col,
  output logic [PIN_W-1:0]       pins
);

  logic [ROW_W-1:0] row_part;
  logic [COL_W-1:0] col_part;

  assign row_part = addr[ROW_W+COL_W-1 -: ROW_W];
  assign col_part = addr[COL_W-1:0];
  assign pins     = sel_col ? PIN_W'(col_part) : PIN_W'(row_part);

endmodule

// File: rtl/adram_rd_capture.sv
module adram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= cap_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (cap_en) rd_data <= dq_in;
  end

  // R6: the valid strobe lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/adram_seq.sv
module adram_seq
  import adram_pkg::*;
#(
  parameter int ROW_W    = 9,
  parameter int COL_W    = 9,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 10,
  parameter int T_SU_NS  = 0,
  parameter int T_RAH_NS = 10,
  parameter int T_RAC_NS = 60,
  parameter int T_CAC_NS = 15,
  parameter int T_RC_NS  = 110
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic                                 req_write,
  input  logic [ROW_W+COL_W-1:0]               req_addr,
  input  logic [DATA_W-1:0]                    req_wdata,
  input  logic                                 late_rd,
  input  logic                                 late_wr,
  output logic                                 rd_valid,
  output logic [DATA_W-1:0]                    rd_data,
  output logic [imax(ROW_W, COL_W)-1:0]        mem_a,
  output logic                                 mem_ras_n,
  output logic                                 mem_cas_n,
  output logic                                 mem_we_n,
  output logic                                 mem_oe_n,
  output logic [DATA_W-1:0]                    mem_dq_out,
  output logic                                 mem_dq_oe,
  input  logic [DATA_W-1:0]                    mem_dq_in
);

  localparam int ADDR_W  = ROW_W + COL_W;
  localparam int PIN_W   = imax(ROW_W, COL_W);
  localparam int SU_C    = imax(1, ns_to_cyc(T_SU_NS, CLK_NS));
  localparam int HOLD_C  = imax(1, ns_to_cyc(T_RAH_NS, CLK_NS));
  localparam int TRAC_C  = ns_to_cyc(T_RAC_NS, CLK_NS);
  localparam int TCAC_C  = ns_to_cyc(T_CAC_NS, CLK_NS);
  localparam int TRC_C   = ns_to_cyc(T_RC_NS, CLK_NS);
  // column wait: CAS lead cycle plus this must cover tCAC, and
  // row hold + col setup + lead + this must cover tRAC
  localparam int WAIT_C  = imax(1, imax(TCAC_C - 1, TRAC_C - HOLD_C - SU_C - 1));
  localparam int LOW_C   = HOLD_C + SU_C + WAIT_C + 3;
  localparam int PRE_C   = imax(1, TRC_C - LOW_C - 1 - SU_C);
  localparam int MAX_C   = imax(imax(SU_C, HOLD_C), imax(WAIT_C, PRE_C));
  localparam int CNT_W   = $clog2(MAX_C) + 1;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  seq_state_e        state_q, state_d;
  pin_ctl_t          ctl_q, ctl_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q, lrd_q, lwr_q;
  logic              accept, tmr_load, tmr_done, cap_en;
  logic [CNT_W-1:0]  tmr_val;

  function automatic int state_len(seq_state_e s);
    case (s)
      S_ROW_SU:   return SU_C;
      S_RAS_HOLD: return HOLD_C;
      S_COL_SU:   return SU_C;
      S_CAS_WAIT: return WAIT_C;
      S_PRE:      return PRE_C;
      default:    return 1;
    endcase
  endfunction

  assign accept = req_valid && ctl_q.ready;

  // next state and timer load
  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (accept)   state_d = S_ROW_SU;
      S_PRE:   if (tmr_done) state_d = S_IDLE;
      default: if (tmr_done) state_d = seq_state_e'(state_q + 4'd1);
    endcase
    tmr_load = (state_d != state_q);
    tmr_val  = CNT_W'(state_len(state_d) - 1);
  end

  // pin decode from the next state
  always_comb begin
    logic col_ph, cas_ph, late_ph;
    col_ph  = (state_d >= S_COL_SU) && (state_d <= S_CAS_OFF);
    cas_ph  = (state_d >= S_CAS_LEAD) && (state_d <= S_OE_OFF);
    late_ph = (state_d == S_CAS_WAIT);
    ctl_d.ras_n   = !((state_d >= S_RAS_HOLD) && (state_d <= S_CAS_OFF));
    ctl_d.cas_n   = !cas_ph;
    ctl_d.sel_col = col_ph;
    ctl_d.oe_n    = !(!wr_q && (late_ph ||
                     (!lrd_q && (state_d == S_COL_SU || state_d == S_CAS_LEAD))));
    ctl_d.we_n    = !(wr_q && (late_ph ||
                     (!lwr_q && (state_d == S_COL_SU || state_d == S_CAS_LEAD))));
    ctl_d.dq_oe   = wr_q && (state_d >= S_COL_SU) && (state_d <= S_OE_OFF);
    ctl_d.ready   = (state_d == S_IDLE);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= S_IDLE;
      ctl_q   <= '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                   dq_oe: 1'b0, sel_col: 1'b0, ready: 1'b1};
    end else begin
      state_q <= state_d;
      ctl_q   <= ctl_d;
    end
  end

  // request capture, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      lrd_q   <= 1'b0;
      lwr_q   <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      wr_q    <= req_write;
      lrd_q   <= late_rd;
      lwr_q   <= late_wr;
    end
  end

  adram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_i),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  adram_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W)) u_amux (
    .addr    (addr_q),
    .sel_col (ctl_q.sel_col),
    .pins    (mem_a)
  );

  assign cap_en = (state_q == S_CAS_WAIT) && tmr_done && !wr_q;

  adram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_i),
    .cap_en   (cap_en),
    .dq_in    (mem_dq_in),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  assign req_ready  = ctl_q.ready;
  assign mem_ras_n  = ctl_q.ras_n;
  assign mem_cas_n  = ctl_q.cas_n;
  assign mem_we_n   = ctl_q.we_n;
  assign mem_oe_n   = ctl_q.oe_n;
  assign mem_dq_oe  = ctl_q.dq_oe;
  assign mem_dq_out = wdata_q;

  // R2: row address steady across the row strobe edge
  a_r2_row_setup: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(mem_ras_n) |-> $stable(mem_a));
  // R4: write-enable low only with the data bus driven
  a_r4_we_drives: assert property (@(posedge clk) disable iff (!rst_i)
    !mem_we_n |-> mem_dq_oe);
  // R5: bus released at least a cycle before output-enable
  a_r5_bus_free: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(mem_oe_n) |-> (!mem_dq_oe && !$past(mem_dq_oe)));
  // R7: column strobe only inside the row strobe
  a_r7_cas_in_ras: assert property (@(posedge clk) disable iff (!rst_i)
    !mem_cas_n |-> !mem_ras_n);
  // R7: enables released before the column strobe rises
  a_r7_enables_first: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(mem_cas_n) |-> ($past(mem_oe_n) && $past(mem_we_n)));
  // R8: busy after acceptance
  a_r8_busy: assert property (@(posedge clk) disable iff (!rst_i)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/adram_seq_tb_top.sv
module adram_seq_tb_top;

  localparam int ROW_W  = 4;
  localparam int COL_W  = 4;
  localparam int DATA_W = 8;
  // expected cycle counts at 20 ns for the chosen part
  localparam int TRAC_C = 9;
  localparam int TCAC_C = 4;
  localparam int TRC_C  = 20;
  localparam int HOLD_C = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, late_rd = 1'b0, late_wr = 1'b0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rd_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [DATA_W-1:0] rd_data, dq_out;
  logic [DATA_W-1:0] dq_in = 8'hEE;
  logic [3:0] a;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  adram_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .CLK_NS(20),
    .T_SU_NS(10), .T_RAH_NS(30), .T_RAC_NS(180), .T_CAC_NS(70), .T_RC_NS(400)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .late_rd(late_rd), .late_wr(late_wr), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_a(a), .mem_ras_n(ras_n), .mem_cas_n(cas_n), .mem_we_n(we_n),
    .mem_oe_n(oe_n), .mem_dq_out(dq_out), .mem_dq_oe(dq_oe), .mem_dq_in(dq_in)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model and pin checker ----------------
  logic [DATA_W-1:0] dram_mem [256];
  logic [DATA_W-1:0] ref_mem  [256];
  logic [7:0] cur_addr;
  bit cur_wr, cur_lr, cur_lw;
  bit p_ras = 1, p_cas = 1, p_oe = 1, p_we = 1, seen_ras = 0, oe_seen_low = 0;
  logic [3:0] p_a = '0, row_l = '0, col_l = '0;
  int ras_age = 0, cas_age = 0, ras_gap = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      ras_gap++;
      if (p_ras && !ras_n) begin
        chk(a == cur_addr[7:4], "R2", "row at RAS fall", a, cur_addr[7:4]);
        chk(p_a == cur_addr[7:4], "R2", "row setup", p_a, cur_addr[7:4]);
        if (seen_ras) chk(ras_gap >= TRC_C, "R8", "RAS fall spacing", ras_gap, TRC_C);
        seen_ras = 1; ras_gap = 0; ras_age = 1; row_l = a;
      end else if (!ras_n) begin
        ras_age++;
        if (ras_age <= HOLD_C) chk(a == row_l, "R2", "row hold", a, row_l);
      end
      if (p_cas && !cas_n) begin
        chk(a == cur_addr[3:0], "R2", "column at CAS fall", a, cur_addr[3:0]);
        if (cur_wr) chk(we_n == cur_lw, "R4", "WE at CAS fall", we_n, cur_lw);
        else        chk(oe_n == cur_lr, "R3", "OE at CAS fall", oe_n, cur_lr);
        cas_age = 1; col_l = a; oe_seen_low = 0;
      end else if (!cas_n) cas_age++;
      if (!cas_n && !oe_n) oe_seen_low = 1;
      if (!p_cas && cas_n) begin
        chk(p_oe && p_we, "R7", "enables high before CAS rise", {p_oe, p_we}, 3);
        if (!cur_wr && cur_lr) chk(oe_seen_low, "R3", "late OE fell under CAS", oe_seen_low, 1);
      end
      if (!p_ras && ras_n) chk(p_cas, "R7", "CAS high before RAS rise", p_cas, 1);
      if (!oe_n && dq_oe) chk(0, "R5", "bus driven with OE low", dq_oe, 0);
      if (!ras_n && !cas_n && !we_n) begin
        chk(dq_oe, "R4", "drive enable during write", dq_oe, 1);
        dram_mem[{row_l, col_l}] = dq_out;
      end
      if (!ras_n && !cas_n && !oe_n && ras_age >= TRAC_C && cas_age >= TCAC_C)
        dq_in = dram_mem[{row_l, col_l}];
      else
        dq_in = 8'hEE;
      p_ras = ras_n; p_cas = cas_n; p_oe = oe_n; p_we = we_n; p_a = a;
    end
  end

  // ---------------- scoreboard monitor ----------------
  logic [DATA_W-1:0] exp_q [$];
  int reads_out = 0;
  bit p_rdv = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        chk(!p_rdv, "R6", "rd_valid single cycle", p_rdv, 0);
        if (exp_q.size() == 0) chk(0, "R6", "unexpected read data", rd_data, 0);
        else begin
          logic [DATA_W-1:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R9", "read data", rd_data, e);
          reads_out++;
        end
      end
      p_rdv = rd_valid;
    end
  end

  // ---------------- driver ----------------
  int reads_in = 0;
  task automatic do_req(input bit wr, input logic [7:0] ad, input logic [7:0] d,
                        input bit lr, input bit lw);
    while (!req_ready) @(negedge clk);
    cur_addr = ad; cur_wr = wr; cur_lr = lr; cur_lw = lw;
    req_valid = 1; req_write = wr; req_addr = ad; req_wdata = d;
    late_rd = lr; late_wr = lw;
    if (wr) ref_mem[ad] = d;
    else begin
      exp_q.push_back(ref_mem[ad]);
      reads_in++;
    end
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R8", "ready low after accept", req_ready, 0);
    req_addr = ~ad; req_write = ~wr;
  endtask

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      dram_mem[i] = 8'(i) ^ 8'h5A;
      ref_mem[i]  = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(ras_n && cas_n && we_n && oe_n, "R1", "strobes idle high",
        {ras_n, cas_n, we_n, oe_n}, 15);
    chk(!dq_oe, "R1", "drive enable low", dq_oe, 0);
    chk(req_ready && !rd_valid, "R1", "ready high, no valid", {req_ready, rd_valid}, 2);
    // R4 early and late writes, R3 early and late reads
    do_req(1, 8'h3C, 8'hA1, 0, 0);
    do_req(1, 8'h3D, 8'hB2, 0, 1);
    do_req(1, 8'hF0, 8'hC3, 1, 0);
    do_req(0, 8'h3C, 8'h00, 0, 0);
    do_req(0, 8'h3D, 8'h00, 1, 0);
    do_req(0, 8'hF0, 8'h00, 1, 1);
    do_req(0, 8'h07, 8'h00, 0, 1);     // never written
    do_req(1, 8'h3C, 8'h5E, 1, 1);     // overwrite, late write
    do_req(0, 8'h3C, 8'h00, 1, 0);
    do_req(1, 8'h00, 8'hFF, 0, 0);
    do_req(0, 8'h00, 8'h00, 0, 0);
    do_req(0, 8'hFF, 8'h00, 1, 1);
    while (!req_ready || exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(reads_out == reads_in, "R6", "all reads returned", reads_out, reads_in);
    chk(ras_n && cas_n && !dq_oe, "R7", "idle after last access", {ras_n, cas_n, dq_oe}, 6);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule